// File: doc/BRIEF.md
# PHY Calibration Write Sequencer

This block runs the short tuning pass a high-speed serial PHY needs once its host controller is up. It issues three override writes, one after another, through a control-register port master. The first write adjusts the loss-of-signal detector bias. The second raises the transmit boost level. The third programs how long the receiver-detect measurement waits, and that value is chosen from the reference-clock frequency in use.

A single start pulse launches the pass. The reference-clock code is captured at that moment. Each write goes out as a one-cycle request, with address and data held steady until the port master answers with a done or an error pulse. Only after that answer does the next write go out. An error ends the pass at once. The outcome appears as a one-cycle done or failed pulse, and a sticky pass flag keeps the result until the next accepted start.

Top module: `phy_calib_seq`

## Requirements
- R1: While reset is held and after it is released, port_req_o, cal_done_o, cal_fail_o and cal_pass_o are all 0.
- R2: When start_i is accepted in idle, port_req_o pulses high in the next cycle with address 0x0015 and data 0xA409: bias 5 at bit 13, override enable at bit 10, level 9 at bit 0.
- R3: The cycle after the first write's done, a request carries address 0x0012 and data 0xA000, which is boost level 5 at bit 13.
- R4: The cycle after the second write's done, a request carries address 0x1010 and a measurement time placed at bit 4. For refclk_sel_i code 3 (50 MHz) the data is 0x0200. For codes 0 (19.2 MHz) and 1 (20 MHz) it is 0x0040. For code 2 (24 MHz) and codes 4 to 7 it is 0x0080.
- R5: refclk_sel_i is sampled only when start is accepted. Changing it during a pass does not alter the third write's data.
- R6: Between requests, port_req_o stays low and port_addr_o and port_data_o hold their values. No new write is launched until port_done_i or port_err_i arrives.
- R7: If port_err_i arrives while any write is pending, cal_fail_o pulses for one cycle in the next cycle. No further request follows, and cal_pass_o is 0.
- R8: The cycle after the third write's done, cal_done_o pulses for one cycle and cal_pass_o becomes 1. cal_pass_o stays 1 until the next accepted start clears it.
- R9: start_i is ignored while a pass is in progress, including the cycle in which the final done arrives.
- R10: If port_done_i and port_err_i arrive in the same cycle, the error wins: cal_fail_o pulses and cal_done_o does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for the calibration pass |
| refclk_sel_i | input | 3 | Reference-clock code, captured at start |
| port_addr_o | output | 16 | Register address for the port master |
| port_data_o | output | 16 | Write data for the port master |
| port_req_o | output | 1 | One-cycle write request |
| port_done_i | input | 1 | Port master reports the write finished |
| port_err_i | input | 1 | Port master reports the write failed |
| cal_done_o | output | 1 | One-cycle pulse: pass completed |
| cal_fail_o | output | 1 | One-cycle pulse: pass aborted |
| cal_pass_o | output | 1 | Sticky result of the last pass |

## Verification
Two pairs of events can collide in one cycle.

The first pair is the port master's done and error. The bench raises both together on each of the three writes. It then expects only the failed pulse, with no further request and the pass flag low.

The second pair is a new start and the final done of a pass. The bench drives start in the very cycle the last done arrives. It expects the done pulse, a set pass flag, and no new first-write request in the following cycle.

// File: rtl/phy_calib_pkg.sv
package phy_calib_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    localparam int unsigned NUM_STEPS = 3;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

    // step order is behaviour: loss-of-signal, boost, measurement time
    localparam logic [STEP_W-1:0] STEP_LOS   = STEP_W'(0);
    localparam logic [STEP_W-1:0] STEP_BOOST = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_MEAS  = STEP_W'(2);

    // reference clock codes
    localparam int unsigned REF_19M2 = 0;
    localparam int unsigned REF_20M  = 1;
    localparam int unsigned REF_24M  = 2;
    localparam int unsigned REF_50M  = 3;

endpackage

// File: rtl/phy_calib_lut.sv
module phy_calib_lut
    import phy_calib_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned MEAS_LSB = 4
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int unsigned LOS_BIAS    = 5;
    localparam int unsigned BIAS_LSB    = 13;
    localparam int unsigned OVRD_EN_BIT = 10;
    localparam int unsigned LOS_LEVEL   = 9;
    localparam int unsigned VBOOST      = 5;

    localparam logic [ADDR_W-1:0] A_LOS   = ADDR_W'(32'h0015);
    localparam logic [ADDR_W-1:0] A_BOOST = ADDR_W'(32'h0012);
    localparam logic [ADDR_W-1:0] A_MEAS  = ADDR_W'(32'h1010);

    localparam logic [DATA_W-1:0] D_LOS =
        DATA_W'((LOS_BIAS << BIAS_LSB) | (1 << OVRD_EN_BIT) | LOS_LEVEL);
    localparam logic [DATA_W-1:0] D_BOOST = DATA_W'(VBOOST << BIAS_LSB);

    localparam int unsigned NUM_SEL = 1 << SEL_W;

    // measurement time per code, built by generate
    logic [DATA_W-1:0] meas_tbl [NUM_SEL];

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_meas
        if (g == REF_50M) begin : g_fast
            assign meas_tbl[g] = DATA_W'(32'h20 << MEAS_LSB);
        end else if (g == REF_19M2 || g == REF_20M) begin : g_slow
            assign meas_tbl[g] = DATA_W'(32'h4 << MEAS_LSB);
        end else begin : g_mid
            assign meas_tbl[g] = DATA_W'(32'h8 << MEAS_LSB);
        end
    end

    always_comb begin
        unique case (step_i)
            STEP_LOS: begin
                addr_o = A_LOS;
                data_o = D_LOS;
            end
            STEP_BOOST: begin
                addr_o = A_BOOST;
                data_o = D_BOOST;
            end
            STEP_MEAS: begin
                addr_o = A_MEAS;
                data_o = meas_tbl[sel_i];
            end
            default: begin
                addr_o = '0;
                data_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/phy_calib_fsm.sv
module phy_calib_fsm
    import phy_calib_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              ack_i,
    input  logic              err_i,
    output logic [STEP_W-1:0] step_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              req_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              pass_o
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [SEL_W-1:0]  sel;
        logic              req;
        logic              done;
        logic              fail;
        logic              pass;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.req  = 1'b0;
        seq_d.done = 1'b0;
        seq_d.fail = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_WAIT;
                    seq_d.step  = STEP_LOS;
                    seq_d.sel   = sel_i;
                    seq_d.req   = 1'b1;
                    seq_d.pass  = 1'b0;
                end
            end
            ST_WAIT: begin
                if (err_i) begin
                    seq_d.state = ST_IDLE;
                    seq_d.fail  = 1'b1;
                end else if (ack_i) begin
                    if (seq_q.step == LAST_STEP) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.pass  = 1'b1;
                    end else begin
                        seq_d.step = seq_q.step + STEP_W'(1);
                        seq_d.req  = 1'b1;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, step: '0, sel: '0,
                       req: 1'b0, done: 1'b0, fail: 1'b0, pass: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign step_o = seq_q.step;
    assign sel_o  = seq_q.sel;
    assign req_o  = seq_q.req;
    assign done_o = seq_q.done;
    assign fail_o = seq_q.fail;
    assign pass_o = seq_q.pass;

endmodule

// File: rtl/phy_calib_seq.sv
module phy_calib_seq
    import phy_calib_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned MEAS_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  refclk_sel_i,
    output logic [ADDR_W-1:0] port_addr_o,
    output logic [DATA_W-1:0] port_data_o,
    output logic              port_req_o,
    input  logic              port_done_i,
    input  logic              port_err_i,
    output logic              cal_done_o,
    output logic              cal_fail_o,
    output logic              cal_pass_o
);

    logic [STEP_W-1:0] step_w;
    logic [SEL_W-1:0]  sel_w;

    phy_calib_fsm #(
        .SEL_W (SEL_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .sel_i   (refclk_sel_i),
        .ack_i   (port_done_i),
        .err_i   (port_err_i),
        .step_o  (step_w),
        .sel_o   (sel_w),
        .req_o   (port_req_o),
        .done_o  (cal_done_o),
        .fail_o  (cal_fail_o),
        .pass_o  (cal_pass_o)
    );

    phy_calib_lut #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W),
        .MEAS_LSB (MEAS_LSB)
    ) u_lut (
        .step_i (step_w),
        .sel_i  (sel_w),
        .addr_o (port_addr_o),
        .data_o (port_data_o)
    );

endmodule

// File: rtl/phy_calib_seq_chk.sv
module phy_calib_seq_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] port_addr_o,
    input logic [DATA_W-1:0] port_data_o,
    input logic              port_req_o,
    input logic              port_done_i,
    input logic              port_err_i,
    input logic              cal_done_o,
    input logic              cal_fail_o,
    input logic              cal_pass_o
);

    // R6: a request lasts one cycle
    p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_req_o |=> !port_req_o);

    // R6: address and data only move together with a new request
    p_hold_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !port_req_o |-> ($stable(port_addr_o) && $stable(port_data_o)));

    // R6: a request follows a start or a done
    p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_req_o |-> ($past(start_i) || $past(port_done_i)));

    // R7: failure follows a port error and leaves the pass flag low
    p_fail_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fail_o |-> ($past(port_err_i) && !cal_pass_o && !port_req_o));

    // R8: done pulse is single and sets the pass flag
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |-> (cal_pass_o && !port_req_o));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |=> !cal_done_o);

    // R10: an error in the same cycle suppresses done
    p_err_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |-> ($past(port_done_i) && !$past(port_err_i)));

    p_no_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_done_o && cal_fail_o));

endmodule

bind phy_calib_seq phy_calib_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .port_addr_o (port_addr_o),
    .port_data_o (port_data_o),
    .port_req_o  (port_req_o),
    .port_done_i (port_done_i),
    .port_err_i  (port_err_i),
    .cal_done_o  (cal_done_o),
    .cal_fail_o  (cal_fail_o),
    .cal_pass_o  (cal_pass_o)
);

// File: tb/phy_calib_seq_test.sv
module phy_calib_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic        pdone = 1'b0;
    logic        perr = 1'b0;
    logic [15:0] addr;
    logic [15:0] data;
    logic        req;
    logic        cdone;
    logic        cfail;
    logic        cpass;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    phy_calib_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .refclk_sel_i (sel),
        .port_addr_o  (addr),
        .port_data_o  (data),
        .port_req_o   (req),
        .port_done_i  (pdone),
        .port_err_i   (perr),
        .cal_done_o   (cdone),
        .cal_fail_o   (cfail),
        .cal_pass_o   (cpass)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input int k);
        case (k)
            0: return 16'h0015;
            1: return 16'h0012;
            default: return 16'h1010;
        endcase
    endfunction

    function automatic logic [15:0] exp_data(input int k, input logic [2:0] s);
        int t;
        case (k)
            0: return 16'((5 << 13) + (1 << 10) + 9);
            1: return 16'(5 << 13);
            default: begin
                if (s == 3'd3) t = 32;
                else if (s <= 3'd1) t = 4;
                else t = 8;
                return 16'(t * 16);
            end
        endcase
    endfunction

    // err_step: -1 for a clean pass; both: raise done together with err
    task automatic run(input logic [2:0] s, input int err_step, input bit both, input bit start_at_end);
        logic [15:0] held;
        @(negedge clk);
        start = 1'b1;
        sel   = s;
        @(negedge clk);
        start = 1'b0;
        sel   = ~s;                          // R5: later change must not matter
        chk("R2 req", 32'(req), 32'd1);
        chk("R2 addr", 32'(addr), 32'(exp_addr(0)));
        chk("R2 data", 32'(data), 32'(exp_data(0, s)));
        chk("R8 pass cleared by start", 32'(cpass), 32'd0);
        for (int k = 0; k < 3; k++) begin
            held = data;
            for (int w = 0; w < k + 1; w++) begin
                if (w == 0) start = 1'b1;      // R9: start while busy
                @(negedge clk);
                start = 1'b0;
                chk("R9 no req while busy", 32'(req), 32'd0);
                chk("R6 addr held", 32'(addr), 32'(exp_addr(k)));
                chk("R6 data held", 32'(data), 32'(held));
            end
            if (k == err_step) begin
                perr  = 1'b1;
                pdone = both;
            end else begin
                pdone = 1'b1;
                if (k == 2 && start_at_end) start = 1'b1;
            end
            @(negedge clk);
            pdone = 1'b0;
            perr  = 1'b0;
            start = 1'b0;
            if (k == err_step) begin
                chk(both ? "R10 fail wins" : "R7 fail pulse", 32'(cfail), 32'd1);
                chk(both ? "R10 no done" : "R7 no done", 32'(cdone), 32'd0);
                chk("R7 no req after err", 32'(req), 32'd0);
                chk("R7 pass low", 32'(cpass), 32'd0);
                @(negedge clk);
                chk("R7 fail one cycle", 32'(cfail), 32'd0);
                chk("R7 stays stopped", 32'(req), 32'd0);
                return;
            end
            if (k < 2) begin
                chk(k == 0 ? "R3 req" : "R4 req", 32'(req), 32'd1);
                chk(k == 0 ? "R3 addr" : "R4 addr", 32'(addr), 32'(exp_addr(k + 1)));
                chk(k == 0 ? "R3 data" : "R4 R5 data", 32'(data), 32'(exp_data(k + 1, s)));
            end else begin
                chk("R8 done pulse", 32'(cdone), 32'd1);
                chk("R8 pass set", 32'(cpass), 32'd1);
                chk("R8 no fail", 32'(cfail), 32'd0);
                chk("R9 req at end", 32'(req), 32'd0);
                @(negedge clk);
                chk("R8 done one cycle", 32'(cdone), 32'd0);
                chk("R8 pass sticky", 32'(cpass), 32'd1);
                chk("R9 start at final done ignored", 32'(req), 32'd0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req in reset", 32'(req), 32'd0);
        chk("R1 pass in reset", 32'(cpass), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 req", 32'(req), 32'd0);
        chk("R1 done", 32'(cdone), 32'd0);
        chk("R1 fail", 32'(cfail), 32'd0);
        chk("R1 pass", 32'(cpass), 32'd0);
        for (int s = 0; s < 8; s++) run(3'(s), -1, 1'b0, s[0]);
        for (int e = 0; e < 3; e++) begin
            run(3'd3, e, 1'b0, 1'b0);
            run(3'd0, e, 1'b1, 1'b0);
        end
        run(3'd2, -1, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8 pass holds when idle", 32'(cpass), 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule